// File: doc/BRIEF.md
# Multiframe Phase Sync Monitor

This block watches the phase indication that a byte-synchronous tributary carries in every frame. The phase indication counts frames inside a 48-frame multiframe. The block keeps its own frame counter and compares it with the received value on every frame strobe. At the last frame of each multiframe it judges the whole multiframe as clean or errored. Two clean multiframes in a row declare phase lock. A programmable run of errored multiframes declares loss of phase.

While phase is lost, the block replaces the received signaling bits with a configured default and raises a request for downstream alarm insertion, unless an inhibit input is set. Every change of the loss status sets a sticky delta flag, which drives an interrupt line unless that line is masked. Clearing the enable input stops synchronization, holds the status and delta outputs at zero, and returns the internal state to its reset condition.

Top module: `mfp_monitor`

## Requirements
- R1: The expected phase value is a frame index that is 0 after reset or re-enable, steps by one on each `frame_stb`, and wraps from 47 to 0. A strobed frame whose `phase_in` differs from the expected index marks its multiframe as errored. The multiframe is judged on the strobe of index 47.
- R2: While in loss, two consecutive clean multiframes clear `loss_o`. The change is visible after the clock edge that samples the strobe of frame 47 of the second clean multiframe.
- R3: While locked, `loss_o` rises when the count of consecutive errored multiframes reaches `cfg_err_limit`. A limit of 0 acts as 1. A clean multiframe resets the count.
- R4: While in loss, a mismatching frame whose `phase_in` is below 48 realigns the counter, so that this frame takes index `phase_in`. The multiframe containing the realigned frame counts as errored.
- R5: When `cfg_enable`=1, loss holds and `cfg_alarm_inh`=0, `alarm_req_o` is 1 and `sig_out` equals `cfg_default_sig` one clock later. Otherwise `alarm_req_o` is 0 and `sig_out` equals `sig_in` delayed by one clock.
- R6: Each change of the loss state while enabled sets `delta_o`, which stays set until `delta_clr`. `irq_o` is `delta_o` gated by `cfg_int_mask`=0.
- R7: With `cfg_enable`=0, `loss_o`, `delta_o` and `alarm_req_o` are 0. Re-enabling starts from the reset state, with loss set and the counters cleared.
- R8: After reset with the block enabled, `loss_o`=1, `delta_o`=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Enables phase synchronization |
| cfg_err_limit | input | LIM_W | Errored multiframes needed to declare loss |
| cfg_alarm_inh | input | 1 | Inhibits default substitution and the alarm request |
| cfg_int_mask | input | 1 | Masks the interrupt |
| cfg_default_sig | input | SIG_W | Signaling value forced while phase is lost |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| phase_in | input | IDX_W | Received phase indication (frame index) |
| sig_in | input | SIG_W | Received signaling bits |
| delta_clr | input | 1 | Clears the delta flag |
| loss_o | output | 1 | Loss of phase status |
| delta_o | output | 1 | Sticky flag for a change of status |
| irq_o | output | 1 | Interrupt request |
| sig_out | output | SIG_W | Selected signaling bits |
| alarm_req_o | output | 1 | Downstream alarm insertion request |

## Verification
A table of whole multiframes, clean or carrying one bad frame, is walked from reset. It tells lock after two clean multiframes apart from lock after one, and a consecutive error count apart from a cumulative one, because a clean multiframe sits between errored ones. A stream that starts at frame 10 instead of 0 separates a monitor that realigns from one that never locks. Toggling the enable and inhibit inputs around a loss state shows whether the default is forced, the signaling passes through, or the status is held at zero. A zero error limit and the mask input cover the edges of the loss count and of the interrupt.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  localparam int MFP_MF_LEN  = 48;  // frames per multiframe
  localparam int MFP_LOCK_MF = 2;   // clean multiframes to declare lock
  localparam int MFP_LIM_W   = 4;   // width of the loss threshold
  localparam int MFP_SIG_W   = 4;   // signaling bits per frame
endpackage

// File: rtl/mfp_align.sv
// Frame counter, phase comparison and per-multiframe error accumulation.
module mfp_align #(
  parameter int MF_LEN = mfp_pkg::MFP_MF_LEN,
  parameter int IDX_W  = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_stb,
  input  logic [IDX_W-1:0] phase_in,
  input  logic             locked,
  output logic             mf_end,
  output logic             mf_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MF_LEN - 1);

  logic [IDX_W-1:0] idx_q, idx_nxt, cur_idx;
  logic             err_q, err_nxt;
  logic             match, realign, last, err_acc, upd;

  always_comb begin
    match   = (phase_in == idx_q);
    realign = !locked && !match && (phase_in <= LAST_IDX);
    cur_idx = realign ? phase_in : idx_q;
    last    = (cur_idx == LAST_IDX);
    err_acc = err_q || !match;
    upd     = !en || frame_stb;
    idx_nxt = idx_q;
    err_nxt = err_q;
    if (!en) begin
      idx_nxt = '0;
      err_nxt = 1'b0;
    end else if (frame_stb) begin
      idx_nxt = last ? '0 : cur_idx + 1'b1;
      err_nxt = last ? 1'b0 : err_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else if (upd) begin
      idx_q <= idx_nxt;
      err_q <= err_nxt;
    end
  end

  assign mf_end = en && frame_stb && last;
  assign mf_err = err_acc;

  // R1: a matching frame below the wrap point advances the counter by one
  a_r1_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_stb && match && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/mfp_judge.sv
// Multiframe verdicts: lock and loss decisions, delta flag, interrupt.
module mfp_judge #(
  parameter int LIM_W   = mfp_pkg::MFP_LIM_W,
  parameter int LOCK_MF = mfp_pkg::MFP_LOCK_MF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mf_end,
  input  logic             mf_err,
  input  logic [LIM_W-1:0] lim,
  input  logic             delta_clr,
  input  logic             int_mask,
  output logic             loss_q,
  output logic             delta_q,
  output logic             irq
);
  localparam int GOOD_W = $clog2(LOCK_MF + 1);
  localparam logic [LIM_W-1:0]  BAD_MAX  = {LIM_W{1'b1}};
  localparam logic [GOOD_W-1:0] GOOD_TGT = GOOD_W'(LOCK_MF);

  logic [GOOD_W-1:0] good_q, good_nxt, good_inc;
  logic [LIM_W-1:0]  bad_q, bad_nxt, bad_inc, lim_eff;
  logic              loss_nxt, delta_nxt;

  always_comb begin
    lim_eff   = (lim == '0) ? LIM_W'(1) : lim;
    bad_inc   = (bad_q == BAD_MAX) ? bad_q : bad_q + 1'b1;
    good_inc  = good_q + 1'b1;
    good_nxt  = good_q;
    bad_nxt   = bad_q;
    loss_nxt  = loss_q;
    delta_nxt = delta_q;
    if (!en) begin
      good_nxt  = '0;
      bad_nxt   = '0;
      loss_nxt  = 1'b1;
      delta_nxt = 1'b0;
    end else begin
      if (mf_end) begin
        if (mf_err) begin
          good_nxt = '0;
          bad_nxt  = bad_inc;
          if (bad_inc >= lim_eff) loss_nxt = 1'b1;
        end else begin
          bad_nxt = '0;
          if (loss_q) begin
            if (good_inc >= GOOD_TGT) begin
              loss_nxt = 1'b0;
              good_nxt = '0;
            end else begin
              good_nxt = good_inc;
            end
          end else begin
            good_nxt = '0;
          end
        end
      end
      if (loss_nxt != loss_q) delta_nxt = 1'b1;
      else if (delta_clr)     delta_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= '0;
      bad_q   <= '0;
      loss_q  <= 1'b1;
      delta_q <= 1'b0;
    end else begin
      good_q  <= good_nxt;
      bad_q   <= bad_nxt;
      loss_q  <= loss_nxt;
      delta_q <= delta_nxt;
    end
  end

  assign irq = delta_q && !int_mask;

  // R2: lock is only declared at the end of a clean multiframe
  a_r2_lock_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loss_q) |-> $past(mf_end && !mf_err));

  // R3: loss while enabled only follows an errored multiframe
  a_r3_loss_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(loss_q) && $past(en)) |-> $past(mf_end && mf_err));

  // R6: a change of state while enabled leaves the delta flag set
  a_r6_delta_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (loss_q != $past(loss_q))) |-> delta_q);
endmodule

// File: rtl/mfp_sigsel.sv
// Signaling output stage: default substitution and alarm request.
module mfp_sigsel #(
  parameter int SIG_W = mfp_pkg::MFP_SIG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             loss,
  input  logic             inh,
  input  logic [SIG_W-1:0] sig_in,
  input  logic [SIG_W-1:0] dflt,
  output logic [SIG_W-1:0] sig_out,
  output logic             alarm
);
  logic             force_dflt;
  logic [SIG_W-1:0] sig_q, sig_nxt;

  always_comb begin
    force_dflt = en && loss && !inh;
    sig_nxt    = force_dflt ? dflt : sig_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_nxt;
  end

  assign sig_out = sig_q;
  assign alarm   = force_dflt;

  // R5: while substitution is active the output carries the default one clock later
  a_r5_default_sub: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(force_dflt)) |-> (sig_q == $past(dflt)));
endmodule

// File: rtl/mfp_monitor.sv
// Top level: multiframe phase synchronization monitor.
module mfp_monitor #(
  parameter int MF_LEN  = mfp_pkg::MFP_MF_LEN,
  parameter int LOCK_MF = mfp_pkg::MFP_LOCK_MF,
  parameter int LIM_W   = mfp_pkg::MFP_LIM_W,
  parameter int SIG_W   = mfp_pkg::MFP_SIG_W,
  localparam int IDX_W  = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [LIM_W-1:0] cfg_err_limit,
  input  logic             cfg_alarm_inh,
  input  logic             cfg_int_mask,
  input  logic [SIG_W-1:0] cfg_default_sig,
  input  logic             frame_stb,
  input  logic [IDX_W-1:0] phase_in,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             delta_clr,
  output logic             loss_o,
  output logic             delta_o,
  output logic             irq_o,
  output logic [SIG_W-1:0] sig_out,
  output logic             alarm_req_o
);
  logic mf_end, mf_err, loss_q, delta_q, irq_int;

  mfp_align #(.MF_LEN(MF_LEN), .IDX_W(IDX_W)) u_align (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .frame_stb(frame_stb),
    .phase_in(phase_in), .locked(!loss_q), .mf_end(mf_end), .mf_err(mf_err)
  );

  mfp_judge #(.LIM_W(LIM_W), .LOCK_MF(LOCK_MF)) u_judge (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .mf_end(mf_end), .mf_err(mf_err),
    .lim(cfg_err_limit), .delta_clr(delta_clr), .int_mask(cfg_int_mask),
    .loss_q(loss_q), .delta_q(delta_q), .irq(irq_int)
  );

  mfp_sigsel #(.SIG_W(SIG_W)) u_sigsel (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .loss(loss_q), .inh(cfg_alarm_inh),
    .sig_in(sig_in), .dflt(cfg_default_sig), .sig_out(sig_out), .alarm(alarm_req_o)
  );

  assign loss_o  = cfg_enable && loss_q;
  assign delta_o = cfg_enable && delta_q;
  assign irq_o   = cfg_enable && irq_int;

  // R7: a disabled cycle leaves the delta flag cleared
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !delta_q);
endmodule

// File: tb/mfp_monitor_test.sv
module mfp_monitor_test;
  localparam int SIG_W = 4;
  localparam int LIM_W = 4;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_enable, cfg_alarm_inh, cfg_int_mask;
  logic [LIM_W-1:0] cfg_err_limit;
  logic [SIG_W-1:0] cfg_default_sig, sig_in, sig_out;
  logic             frame_stb, delta_clr;
  logic [IDX_W-1:0] phase_in;
  logic             loss_o, delta_o, irq_o, alarm_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mfp_monitor uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_err_limit(cfg_err_limit),
    .cfg_alarm_inh(cfg_alarm_inh), .cfg_int_mask(cfg_int_mask),
    .cfg_default_sig(cfg_default_sig), .frame_stb(frame_stb), .phase_in(phase_in),
    .sig_in(sig_in), .delta_clr(delta_clr), .loss_o(loss_o), .delta_o(delta_o),
    .irq_o(irq_o), .sig_out(sig_out), .alarm_req_o(alarm_req_o)
  );

  // per multiframe: {inject one bad frame, expected loss, expected delta}
  localparam logic [2:0] VEC [0:9] = '{
    3'b010, 3'b001, 3'b100, 3'b000, 3'b100,
    3'b100, 3'b111, 3'b010, 3'b001, 3'b100
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int ph);
    @(negedge clk);
    phase_in  = IDX_W'(ph);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic send_mf(input bit inject);
    for (int f = 0; f < 48; f++)
      send_frame((inject && f == 20) ? f + 1 : f);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    delta_clr = 1'b1;
    @(negedge clk);
    delta_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_alarm_inh = 1'b0; cfg_int_mask = 1'b0;
    cfg_err_limit = 4'd3; cfg_default_sig = 4'h3; sig_in = 4'h0;
    frame_stb = 1'b0; delta_clr = 1'b0; phase_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8 loss after reset", loss_o, 1);
    check("R8 delta after reset", delta_o, 0);
    check("R8 irq after reset", irq_o, 0);

    // R1 R2 R3 R6: multiframe table
    for (int i = 0; i < 10; i++) begin
      pulse_clr();
      send_mf(VEC[i][2]);
      check($sformatf("R2/R3 loss table %0d", i), loss_o, VEC[i][1]);
      check($sformatf("R6 delta table %0d", i), delta_o, VEC[i][0]);
    end

    // R5: locked, pass-through
    @(negedge clk); sig_in = 4'hA;
    @(negedge clk);
    check("R5 passthrough locked", sig_out, 4'hA);
    check("R5 no alarm locked", alarm_req_o, 0);

    // R7: disabled
    cfg_enable = 1'b0; sig_in = 4'h5;
    @(negedge clk);
    check("R7 loss disabled", loss_o, 0);
    check("R7 delta disabled", delta_o, 0);
    check("R7 alarm disabled", alarm_req_o, 0);
    send_frame(7);
    check("R7 loss disabled after frame", loss_o, 0);
    check("R5 passthrough disabled", sig_out, 4'h5);

    // R7 R5: re-enable returns to loss and forces default
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R7 loss after re-enable", loss_o, 1);
    check("R5 alarm in loss", alarm_req_o, 1);
    check("R5 default in loss", sig_out, 4'h3);
    cfg_alarm_inh = 1'b1;
    @(negedge clk);
    check("R5 inhibit alarm", alarm_req_o, 0);
    check("R5 inhibit passthrough", sig_out, 4'h5);
    cfg_alarm_inh = 1'b0;

    // R4: stream starting at frame 10 must realign
    for (int f = 10; f < 48; f++) send_frame(f);
    send_mf(1'b0);
    check("R4 still loss after one clean", loss_o, 1);
    send_mf(1'b0);
    check("R4 lock after realign", loss_o, 0);
    check("R6 delta on lock", delta_o, 1);
    check("R6 irq unmasked", irq_o, 1);
    cfg_int_mask = 1'b1;
    @(negedge clk);
    check("R6 irq masked", irq_o, 0);
    cfg_int_mask = 1'b0;
    pulse_clr();
    check("R6 delta cleared", delta_o, 0);

    // R3: limit zero behaves as one
    cfg_err_limit = 4'd0;
    send_mf(1'b1);
    check("R3 limit zero loss", loss_o, 1);
    check("R6 delta on loss", delta_o, 1);

    // R8: reset again
    do_reset();
    check("R8 loss after second reset", loss_o, 1);
    check("R8 delta after second reset", delta_o, 0);
    check("R8 irq after second reset", irq_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule